// File: doc/BRIEF.md
# Nine-bit serial command/data transmitter

This block sends display-controller traffic over a serial link in which every word is a data/command flag followed by an eight-bit payload. A host hands it one byte and its flag at a time on a valid/ready handshake. The block drives a serial clock, a data line and an active-low chip select. Clocking follows SPI mode 0: the clock idles low, data changes while the clock is low, and the receiver samples on the rising edge.

A mode input picks one of two framings. In native mode each word goes out as a nine-clock frame. In packed mode the nine-bit words are joined in arrival order and cut into eight-bit bytes from the top. A byte is clocked out only once eight bits are held, so eight words fill exactly nine bytes. This lets the block feed a link that only moves whole bytes. A flush request ends the transaction. It pads any partial byte with zeros, lets the last frame finish, and then releases chip select. Clock speed is set by a divider input.

Top module: `dc9_serial_tx`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0 and in_ready is 1.
- R2: A word goes out flag first (0 = command, 1 = parameter or pixel data), then payload bit 7 down to bit 0. The data line changes only while sclk is low, and each bit is valid at the rising sclk edge.
- R3: With mode_pack = 0, each accepted word produces one frame of exactly 9 sclk rising edges, and frames follow the order of acceptance.
- R4: With mode_pack = 1, eight accepted words produce exactly 72 sclk rising edges. The bits are the nine-bit words concatenated in arrival order, with no padding.
- R5: With mode_pack = 1, a flush after a group that is not a multiple of eight words appends zero bits up to the next multiple of 8 bits before chip select is released.
- R6: With mode_pack = 1, a byte is clocked only when 8 unsent bits are held. After a single word with no flush, exactly 8 rising edges occur, cs_n stays 0, and in_ready returns to 1.
- R7: cs_n goes low with the first frame of a transaction. It stays low at every sclk rising edge and until a requested flush has sent every held bit, then returns to 1.
- R8: in_ready is 0 whenever a frame is being shifted, including at every sclk rising edge.
- R9: Within a frame, consecutive sclk rising edges are 2*(clk_div+1) clock cycles apart.
- R10: A flush while cs_n is 1 and nothing is held produces no sclk edge and leaves cs_n at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Half serial period minus one, in clock cycles |
| mode_pack | input | 1 | 0 = nine-bit frames, 1 = packed eight-bit frames |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken this cycle |
| in_dc | input | 1 | Flag bit: 0 command, 1 data |
| in_byte | input | 8 | Payload byte |
| flush | input | 1 | Request to finish the transaction |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions assume that mode_pack does not change while chip select is low, and that clk_div does not change while a frame is shifting. The stimulus changes both only after a flush has completed and chip select has gone high. Words are presented only on a falling clock edge where in_ready is already high, so a push never coincides with a pop of the bit buffer. The sweep covers every word count from one to nine, both modes and three divider settings.

// File: rtl/dc9_pkg.sv
package dc9_pkg;
    localparam int PAY_W   = 8;
    localparam int FRAME_W = PAY_W + 1;
    localparam int BYTE_W  = 8;
    localparam int ACC_W   = FRAME_W + BYTE_W - 1;
    localparam int CNT_W   = $clog2(ACC_W + 1);

    typedef struct packed {
        logic [ACC_W-1:0] bits;
        logic [CNT_W-1:0] cnt;
    } acc_st_t;

    typedef struct packed {
        logic               busy;
        logic               sclk;
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   left;
    } shf_st_t;

    typedef struct packed {
        logic cs_n;
        logic fl_pend;
    } ctl_st_t;
endpackage

// File: rtl/dc9_tick.sv
module dc9_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || cnt_q == div) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
        tick = run && (cnt_q == div);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9: the count never runs past the divider value while running
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run && $stable(div) |-> cnt_q <= div);
endmodule

// File: rtl/dc9_accum.sv
module dc9_accum import dc9_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [FRAME_W-1:0] word,
    input  logic               pop,
    input  logic [CNT_W-1:0]   pop_n,
    output logic [CNT_W-1:0]   cnt,
    output logic [FRAME_W-1:0] head
);
    localparam int PADZ = ACC_W - FRAME_W;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop) begin
            st_d.bits = st_q.bits << pop_n;
            st_d.cnt  = st_q.cnt - pop_n;
        end
        if (push) begin
            st_d.bits = st_q.bits | ({word, {PADZ{1'b0}}} >> st_q.cnt);
            st_d.cnt  = st_q.cnt + CNT_W'(FRAME_W);
        end
        cnt  = st_q.cnt;
        head = st_q.bits[ACC_W-1 -: FRAME_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> st_q.cnt <= CNT_W'(PADZ));
    a_r6_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
    a_r6_pop_le_held: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> pop_n <= st_q.cnt);
    // R5: bits below the held count are zero, so padding is zero
    a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bits << st_q.cnt) == '0);
endmodule

// File: rtl/dc9_shift.sv
module dc9_shift import dc9_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   len,
    input  logic               tick,
    output logic               busy,
    output logic               sclk,
    output logic               mosi
);
    shf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (load) begin
                st_d.busy = 1'b1;
                st_d.sclk = 1'b0;
                st_d.sr   = frame;
                st_d.left = len;
            end
        end else if (tick) begin
            if (!st_q.sclk) begin
                st_d.sclk = 1'b1;
            end else begin
                st_d.sclk = 1'b0;
                if (st_q.left == CNT_W'(1)) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.sr   = st_q.sr << 1;
                    st_d.left = st_q.left - 1'b1;
                end
            end
        end
        busy = st_q.busy;
        sclk = st_q.sclk;
        mosi = st_q.sr[FRAME_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r2_data_held_high: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sclk |-> $stable(st_q.sr[FRAME_W-1]));
    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> !st_q.sclk);
    a_r9_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.busy) && (st_q.sclk != $past(st_q.sclk)) |-> $past(tick));
endmodule

// File: rtl/dc9_serial_tx.sv
module dc9_serial_tx import dc9_pkg::*; #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             mode_pack,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_dc,
    input  logic [7:0]       in_byte,
    input  logic             flush,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n
);
    localparam logic [CNT_W-1:0] LEN_NAT  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LEN_PACK = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ROOM_MAX = CNT_W'(ACC_W - FRAME_W);

    ctl_st_t            ctl_d, ctl_q;
    logic               busy, tick, push, start;
    logic [CNT_W-1:0]   held, frame_len, pop_n;
    logic [FRAME_W-1:0] head;

    always_comb begin
        frame_len = mode_pack ? LEN_PACK : LEN_NAT;
        start     = !busy && ((held >= frame_len) ||
                              (mode_pack && ctl_q.fl_pend && held != '0));
        pop_n     = (held >= frame_len) ? frame_len : held;
        in_ready  = !busy && (held <= ROOM_MAX) && !ctl_q.fl_pend;
        push      = in_valid && in_ready;

        ctl_d = ctl_q;
        if (start) ctl_d.cs_n = 1'b0;
        if (ctl_q.fl_pend && !busy && held == '0) begin
            ctl_d.cs_n    = 1'b1;
            ctl_d.fl_pend = 1'b0;
        end
        if (flush) ctl_d.fl_pend = 1'b1;
        cs_n = ctl_q.cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{cs_n: 1'b1, fl_pend: 1'b0};
        else        ctl_q <= ctl_d;
    end

    dc9_accum u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .word  ({in_dc, in_byte}),
        .pop   (start),
        .pop_n (pop_n),
        .cnt   (held),
        .head  (head)
    );

    dc9_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (clk_div),
        .tick  (tick)
    );

    dc9_shift u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .frame (head),
        .len   (frame_len),
        .tick  (tick),
        .busy  (busy),
        .sclk  (sclk),
        .mosi  (mosi)
    );

    a_r7_cs_low_clocking: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);
    a_r7_release_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.cs_n) |-> held == '0 && !busy);
    a_r8_hold_while_shift: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !push);
    a_r3_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.cs_n |-> $stable(mode_pack));
    a_r9_div_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(clk_div));
endmodule

// File: tb/dc9_serial_tx_bench.sv
module dc9_serial_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] clk_div = 8'd0;
    logic       mode_pack = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_dc = 1'b0;
    logic [7:0] in_byte = 8'd0;
    logic       flush = 1'b0;
    logic       in_ready, sclk, mosi, cs_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_rise = 0;
    int cap_n = 0;
    int exp_n = 0;
    int cur_len = 9;
    int cur_div = 0;
    bit cap [0:255];
    bit expv [0:255];

    always #5 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    dc9_serial_tx u_dc9_serial_tx (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .mode_pack(mode_pack),
        .in_valid(in_valid), .in_ready(in_ready), .in_dc(in_dc),
        .in_byte(in_byte), .flush(flush), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expd);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expd);
        end
    endtask

    always @(posedge sclk) begin
        chk(cs_n == 1'b0, "R7 cs_n at sclk rise", int'(cs_n), 0);
        chk(in_ready == 1'b0, "R8 in_ready at sclk rise", int'(in_ready), 0);
        if (cap_n > 0 && (cap_n % cur_len) != 0)
            chk(cyc - last_rise == 2 * (cur_div + 1), "R9 rise spacing",
                cyc - last_rise, 2 * (cur_div + 1));
        last_rise = cyc;
        if (cap_n < 256) cap[cap_n] = mosi;
        cap_n++;
    end

    task automatic send(input bit dc, input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_dc = dc; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0;
        expv[exp_n] = dc; exp_n++;
        for (int k = 7; k >= 0; k--) begin expv[exp_n] = b[k]; exp_n++; end
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        @(negedge clk);
        while (!(cs_n && in_ready && !sclk)) @(negedge clk);
    endtask

    task automatic run_txn(input int nw, input bit pk, input int dv, input bit hold_first);
        string tag;
        int bad;
        @(negedge clk);
        mode_pack = pk; clk_div = 8'(dv);
        cur_len = pk ? 8 : 9; cur_div = dv;
        cap_n = 0; exp_n = 0;
        for (int i = 0; i < nw; i++) begin
            send(((i + nw) % 3) != 0, 8'((i * 73 + nw * 29 + dv * 11 + 5) & 255));
            if (hold_first && i == 0) begin
                repeat (60) @(negedge clk);
                chk(cap_n == 8, "R6 edges after one packed word", cap_n, 8);
                chk(cs_n == 1'b0, "R6 cs_n held low", int'(cs_n), 0);
                chk(in_ready == 1'b1, "R6 ready with bit held", int'(in_ready), 1);
            end
        end
        do_flush();
        if (pk) while ((exp_n % 8) != 0) begin expv[exp_n] = 1'b0; exp_n++; end
        tag = !pk ? "R3 native count" : (nw % 8 == 0) ? "R4 packed count" : "R5 padded count";
        chk(cap_n == exp_n, tag, cap_n, exp_n);
        bad = -1;
        for (int k = 0; k < exp_n && k < cap_n; k++)
            if (bad < 0 && cap[k] != expv[k]) bad = k;
        chk(bad < 0, pk ? "R5 packed bitstream (R2 order, R4)" : "R2 bit order (R3 stream)",
            bad, -1);
        chk(cs_n == 1'b1, "R7 cs_n released after flush", int'(cs_n), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 reset cs_n", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1 reset sclk", int'(sclk), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);

        cap_n = 0;
        do_flush();
        repeat (20) @(negedge clk);
        chk(cap_n == 0, "R10 idle flush edges", cap_n, 0);
        chk(cs_n == 1'b1, "R10 idle flush cs_n", int'(cs_n), 1);

        for (int dv = 0; dv < 3; dv++)
            for (int pk = 0; pk < 2; pk++)
                for (int nw = 1; nw <= 9; nw++)
                    run_txn(nw, pk[0], dv, 1'b0);

        run_txn(1, 1'b1, 1, 1'b1);
        run_txn(3, 1'b1, 0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule